// File: doc/BRIEF.md
# Four-Phase Instruction Fetch Sequencer

This block is the fetch and program-counter unit of a small microcontroller core. It divides the system clock into an instruction cycle of four clock periods and marks each period with its own phase strobe. It holds the program counter, which addresses a program memory of 14-bit words. A one-word prefetch keeps fetch and execute overlapped. While the word at the counter is read from memory, the execute stage works on the word fetched one instruction cycle earlier. As a result, straight-line code retires one instruction per instruction cycle.

The execute stage can redirect the flow in four ways: an absolute jump or call target, a return address, a write to the low byte of the counter, and a conditional-skip request. Each accepted redirect discards the word that is already prefetched. That word is replaced by a dummy cycle, presented as a NOP with the valid flag low. A write to the low byte is a short jump: it keeps the upper counter bits, so the destination stays inside the current 256-word page. The low byte of the counter can be read at all times, which lets the execute stage serve reads of that register.

Top module: `ifu_fetch_seq`

## Requirements
- R1: `phase` is one-hot, with bit 0 = T1, bit 1 = T2, bit 2 = T3 and bit 3 = T4. It steps T1, T2, T3, T4 and back to T1, and T1 is the phase of the first clock period after reset is released.
- R2: While reset is held and in the first instruction cycle after it, `mem_addr` is 0, `instr_vld` is 0 and `instr` is the NOP word. In the second instruction cycle, `instr` is the word stored at address 0 and `instr_vld` is 1.
- R3: `mem_addr`, `instr` and `instr_vld` change only at the clock edge that ends T4, so they hold one value through all four phases of an instruction cycle.
- R4: With no accepted request, each instruction cycle presents `mem_addr` one above the previous value, wrapping from 3FFh to 000h. `instr` then carries the word read at the previous address, with `instr_vld` high.
- R5: Requests are acted on only when they are present during T4 and `instr_vld` is high. A request raised only in T1 to T3, or raised during a dummy cycle, has no effect.
- R6: An accepted skip advances `mem_addr` by one and makes the next instruction cycle a dummy.
- R7: An accepted `ld_req` sets the next `mem_addr` to `ld_addr` and inserts one dummy cycle. The cycle after that presents the word at `ld_addr` as valid.
- R8: An accepted `ret_req` sets the next `mem_addr` to `ret_addr` and inserts one dummy cycle. `ld_req` wins over `ret_req`, and `ret_req` wins over a low-byte write.
- R9: An accepted `pcl_we` replaces counter bits 7:0 with `pcl_wdata` and keeps bits 9:8, then inserts one dummy cycle.
- R10: When a skip and any control transfer are accepted in the same instruction cycle, the transfer is taken and exactly one dummy cycle follows.
- R11: During a dummy cycle, `instr` equals the NOP word (default 0) and `instr_vld` is low for all four phases.
- R12: `pcl_rd` always equals bits 7:0 of the current `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 10 | Program memory address (current counter) |
| mem_rdata | input | 14 | Word from the synchronous program memory |
| phase | output | 4 | One-hot phase strobes T1..T4 |
| instr | output | 14 | Word handed to the execute stage |
| instr_vld | output | 1 | High for a real word, low in a dummy cycle |
| ld_req | input | 1 | Jump or call request |
| ld_addr | input | 10 | Jump or call target |
| ret_req | input | 1 | Return request |
| ret_addr | input | 10 | Return address |
| skip_req | input | 1 | Conditional skip taken |
| pcl_we | input | 1 | Write to the counter low byte |
| pcl_wdata | input | 8 | Data for the low-byte write |
| pcl_rd | output | 8 | Current counter low byte |

## Verification
The hardest cases to reach are the requests that must be ignored. One is a request that arrives while the execute stage is itself in a dummy cycle. The other is a request that is withdrawn just before T4. The stimulus reaches the first by raising a new jump or return in the instruction cycle right after a transfer. It reaches the second by raising a jump through T1 to T3 and dropping it at the falling edge before the T4 commit. The scoreboard then expects plain sequential flow in both cases. Priority conflicts (skip against jump, jump against return, return against a low-byte write) are driven in single cycles. A jump to the top of memory lets the counter wrap.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

   // what the counter does at the next T4 commit
   typedef enum logic [2:0] {
      NXT_SEQ,
      NXT_SKIP,
      NXT_LOAD,
      NXT_RET,
      NXT_PAGE
   } nxt_kind_e;

   localparam int unsigned PHASE_N = 4;

endpackage

// File: rtl/ifu_phase_gen.sv
module ifu_phase_gen #(
   parameter bit ONEHOT_RING = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   output logic [ifu_pkg::PHASE_N-1:0]    phase_o,
   output logic                           commit_o
);
   localparam int unsigned CW = $clog2(ifu_pkg::PHASE_N);

   generate
      if (ONEHOT_RING) begin : g_ring
         logic [ifu_pkg::PHASE_N-1:0] ring_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ring_q <= {{(ifu_pkg::PHASE_N-1){1'b0}}, 1'b1};
            else        ring_q <= {ring_q[ifu_pkg::PHASE_N-2:0], ring_q[ifu_pkg::PHASE_N-1]};
         end
         assign phase_o = ring_q;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         always_comb begin
            phase_o = '0;
            phase_o[cnt_q] = 1'b1;
         end
      end
   endgenerate

   assign commit_o = phase_o[ifu_pkg::PHASE_N-1];

endmodule

// File: rtl/ifu_redirect_arb.sv
module ifu_redirect_arb (
   input  logic                commit_i,
   input  logic                exec_vld_i,
   input  logic                ld_req_i,
   input  logic                ret_req_i,
   input  logic                pg_we_i,
   input  logic                skip_req_i,
   output ifu_pkg::nxt_kind_e  kind_o
);
   import ifu_pkg::*;

   logic accept;
   assign accept = commit_i && exec_vld_i;

   // transfers outrank the skip; among transfers: load, return, page write
   always_comb begin
      kind_o = NXT_SEQ;
      if (accept) begin
         if (ld_req_i)        kind_o = NXT_LOAD;
         else if (ret_req_i)  kind_o = NXT_RET;
         else if (pg_we_i)    kind_o = NXT_PAGE;
         else if (skip_req_i) kind_o = NXT_SKIP;
      end
   end

endmodule

// File: rtl/ifu_pc_unit.sv
module ifu_pc_unit #(
   parameter int unsigned PC_W   = 10,
   parameter int unsigned PAGE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit_i,
   input  ifu_pkg::nxt_kind_e  kind_i,
   input  logic [PC_W-1:0]     ld_addr_i,
   input  logic [PC_W-1:0]     ret_addr_i,
   input  logic [PAGE_W-1:0]   pg_wdata_i,
   output logic [PC_W-1:0]     pc_o
);
   import ifu_pkg::*;

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] pc_page;
   logic [PC_W-1:0] pc_nxt;

   assign pc_inc = pc_q + 1'b1;

   generate
      if (PAGE_W < PC_W) begin : g_paged
         assign pc_page = {pc_q[PC_W-1:PAGE_W], pg_wdata_i};
      end else begin : g_flat
         assign pc_page = pg_wdata_i[PC_W-1:0];
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         NXT_LOAD: pc_nxt = ld_addr_i;
         NXT_RET:  pc_nxt = ret_addr_i;
         NXT_PAGE: pc_nxt = pc_page;
         default:  pc_nxt = pc_inc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc_q <= '0;
      else if (commit_i) pc_q <= pc_nxt;
   end

   assign pc_o = pc_q;

endmodule

// File: rtl/ifu_issue_stage.sv
module ifu_issue_stage #(
   parameter int unsigned   IW       = 14,
   parameter logic [IW-1:0] NOP_WORD = '0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                commit_i,
   input  ifu_pkg::nxt_kind_e  kind_i,
   input  logic [IW-1:0]       rdata_i,
   output logic [IW-1:0]       instr_o,
   output logic                vld_o
);
   import ifu_pkg::*;

   logic [IW-1:0] word_q;
   logic          vld_q;

   // prefetched word survives only when flow stays sequential
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= NOP_WORD;
         vld_q  <= 1'b0;
      end else if (commit_i) begin
         if (kind_i == NXT_SEQ) begin
            word_q <= rdata_i;
            vld_q  <= 1'b1;
         end else begin
            word_q <= NOP_WORD;
            vld_q  <= 1'b0;
         end
      end
   end

   assign instr_o = word_q;
   assign vld_o   = vld_q;

endmodule

// File: rtl/ifu_fetch_seq.sv
module ifu_fetch_seq #(
   parameter int unsigned   PC_W      = 10,
   parameter int unsigned   IW        = 14,
   parameter int unsigned   PAGE_W    = 8,
   parameter logic [IW-1:0] NOP_WORD  = '0,
   parameter bit            PH_ONEHOT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic [PC_W-1:0]               mem_addr,
   input  logic [IW-1:0]                 mem_rdata,
   output logic [ifu_pkg::PHASE_N-1:0]   phase,
   output logic [IW-1:0]                 instr,
   output logic                          instr_vld,
   input  logic                          ld_req,
   input  logic [PC_W-1:0]               ld_addr,
   input  logic                          ret_req,
   input  logic [PC_W-1:0]               ret_addr,
   input  logic                          skip_req,
   input  logic                          pcl_we,
   input  logic [PAGE_W-1:0]             pcl_wdata,
   output logic [PAGE_W-1:0]             pcl_rd
);
   import ifu_pkg::*;

   generate
      if (PAGE_W > PC_W || PAGE_W == 0) begin : g_bad_page
         $error("ifu_fetch_seq: PAGE_W must lie in 1..PC_W");
      end
      if (PC_W < 2 || IW < 1) begin : g_bad_width
         $error("ifu_fetch_seq: PC_W must be at least 2 and IW at least 1");
      end
   endgenerate

   logic      commit;
   nxt_kind_e kind;

   ifu_phase_gen #(.ONEHOT_RING(PH_ONEHOT)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_o  (phase),
      .commit_o (commit)
   );

   ifu_redirect_arb u_arb (
      .commit_i   (commit),
      .exec_vld_i (instr_vld),
      .ld_req_i   (ld_req),
      .ret_req_i  (ret_req),
      .pg_we_i    (pcl_we),
      .skip_req_i (skip_req),
      .kind_o     (kind)
   );

   ifu_pc_unit #(.PC_W(PC_W), .PAGE_W(PAGE_W)) u_pc (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (commit),
      .kind_i     (kind),
      .ld_addr_i  (ld_addr),
      .ret_addr_i (ret_addr),
      .pg_wdata_i (pcl_wdata),
      .pc_o       (mem_addr)
   );

   ifu_issue_stage #(.IW(IW), .NOP_WORD(NOP_WORD)) u_issue (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (commit),
      .kind_i   (kind),
      .rdata_i  (mem_rdata),
      .instr_o  (instr),
      .vld_o    (instr_vld)
   );

   assign pcl_rd = mem_addr[PAGE_W-1:0];

endmodule

// File: rtl/ifu_fetch_chk.sv
module ifu_fetch_chk #(
   parameter int unsigned   PC_W     = 10,
   parameter int unsigned   IW       = 14,
   parameter int unsigned   PAGE_W   = 8,
   parameter logic [IW-1:0] NOP_WORD = '0
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [PC_W-1:0]               mem_addr,
   input logic [ifu_pkg::PHASE_N-1:0]   phase,
   input logic [IW-1:0]                 instr,
   input logic                          instr_vld,
   input logic                          ld_req,
   input logic [PC_W-1:0]               ld_addr,
   input logic                          ret_req,
   input logic [PC_W-1:0]               ret_addr,
   input logic                          skip_req,
   input logic                          pcl_we,
   input logic [PAGE_W-1:0]             pcl_wdata
);
   logic any_req;
   logic t4_acc;
   assign any_req = ld_req || ret_req || pcl_we || skip_req;
   assign t4_acc  = phase[3] && instr_vld;

   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(phase) == 1); // R1
   AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      phase[0] |=> phase[1]); // R1
   AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      phase[3] |=> phase[0]); // R1
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !phase[3] |=> $stable(mem_addr)); // R3
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !phase[3] |=> ($stable(instr) && $stable(instr_vld))); // R3
   AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (phase[3] && (!instr_vld || !any_req)) |=>
         (mem_addr == PC_W'($past(mem_addr) + 1'b1) && instr_vld)); // R4
   AST_SKIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (t4_acc && skip_req && !ld_req && !ret_req && !pcl_we) |=>
         (mem_addr == PC_W'($past(mem_addr) + 1'b1) && !instr_vld)); // R6
   AST_LOAD_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (t4_acc && ld_req) |=> (mem_addr == $past(ld_addr) && !instr_vld)); // R7
   AST_RET_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (t4_acc && !ld_req && ret_req) |=> (mem_addr == $past(ret_addr) && !instr_vld)); // R8
   AST_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (t4_acc && !ld_req && !ret_req && pcl_we) |=>
         ((mem_addr >> PAGE_W) == ($past(mem_addr) >> PAGE_W)
          && mem_addr[PAGE_W-1:0] == $past(pcl_wdata) && !instr_vld)); // R9
   AST_NOP_DUMMY: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_vld |-> (instr == NOP_WORD)); // R11

endmodule

bind ifu_fetch_seq ifu_fetch_chk #(
   .PC_W(PC_W), .IW(IW), .PAGE_W(PAGE_W), .NOP_WORD(NOP_WORD)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_addr  (mem_addr),
   .phase     (phase),
   .instr     (instr),
   .instr_vld (instr_vld),
   .ld_req    (ld_req),
   .ld_addr   (ld_addr),
   .ret_req   (ret_req),
   .ret_addr  (ret_addr),
   .skip_req  (skip_req),
   .pcl_we    (pcl_we),
   .pcl_wdata (pcl_wdata)
);

// File: tb/ifu_fetch_seq_tb_top.sv
module ifu_fetch_seq_tb_top;
   localparam int PC_W   = 10;
   localparam int IW     = 14;
   localparam int PAGE_W = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic [PC_W-1:0]   mem_addr;
   logic [IW-1:0]     mem_rdata = '0;
   logic [3:0]        phase;
   logic [IW-1:0]     instr;
   logic              instr_vld;
   logic              ld_req = 0, ret_req = 0, skip_req = 0, pcl_we = 0;
   logic [PC_W-1:0]   ld_addr = '0, ret_addr = '0;
   logic [PAGE_W-1:0] pcl_wdata = '0;
   logic [PAGE_W-1:0] pcl_rd;

   ifu_fetch_seq dut_i (
      .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .phase(phase), .instr(instr), .instr_vld(instr_vld),
      .ld_req(ld_req), .ld_addr(ld_addr), .ret_req(ret_req), .ret_addr(ret_addr),
      .skip_req(skip_req), .pcl_we(pcl_we), .pcl_wdata(pcl_wdata), .pcl_rd(pcl_rd)
   );

   function automatic logic [IW-1:0] word_at(input logic [PC_W-1:0] a);
      logic [IW-1:0] x;
      x = {4'b0, a};
      return ((x * 14'd11 + 14'd3) ^ (x << 4)) | 14'd1;
   endfunction

   // synchronous program memory model
   always @(posedge clk) mem_rdata <= word_at(mem_addr);

   int n_chk = 0;
   int n_fail = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   typedef struct {
      logic [PC_W-1:0] addr;
      logic            vld;
      logic [IW-1:0]   word;
      string           tag;
   } exp_t;
   exp_t sb[$];

   // reference state seen during the current instruction cycle
   logic [PC_W-1:0] m_pc = '0;
   logic            m_vld = 1'b0;
   logic [IW-1:0]   m_word = '0;

   task automatic icycle(input string tag, input bit ld, input logic [PC_W-1:0] la,
                         input bit rt, input logic [PC_W-1:0] ra, input bit sk,
                         input bit we, input logic [PAGE_W-1:0] wd, input bit drop_t4);
      do @(negedge clk); while (!phase[0]);
      sb.push_back('{m_pc, m_vld, m_word, tag});
      ld_req = ld; ld_addr = la; ret_req = rt; ret_addr = ra;
      skip_req = sk; pcl_we = we; pcl_wdata = wd;
      do @(negedge clk); while (!phase[3]);
      if (drop_t4) begin
         ld_req = 0; ret_req = 0; skip_req = 0; pcl_we = 0;
      end
      if (m_vld && !drop_t4 && (ld || rt || we || sk)) begin
         if (ld)      m_pc = la;
         else if (rt) m_pc = ra;
         else if (we) m_pc = {m_pc[PC_W-1:PAGE_W], wd};
         else         m_pc = m_pc + 1'b1;
         m_vld  = 1'b0;
         m_word = '0;
      end else begin
         m_word = word_at(m_pc);
         m_vld  = 1'b1;
         m_pc   = m_pc + 1'b1;
      end
   endtask

   task automatic plain(input string tag);
      icycle(tag, 0, '0, 0, '0, 0, 0, '0, 0);
   endtask

   // monitor: phase order, then compare each instruction cycle at T2, hold check at T4
   logic [3:0]      mon_ph = 4'b0001;
   logic [PC_W-1:0] hold_addr = '0;
   bit              have = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         mon_ph = 4'b0001;
         have = 0;
      end else begin
         check(phase == mon_ph, "R1", "phase", 32'(phase), 32'(mon_ph));
         mon_ph = {mon_ph[2:0], mon_ph[3]};
         if (phase[1] && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(mem_addr == e.addr, e.tag, "mem_addr", 32'(mem_addr), 32'(e.addr));
            check(instr_vld == e.vld, e.tag, "instr_vld", 32'(instr_vld), 32'(e.vld));
            check(instr == e.word, e.tag, "instr", 32'(instr), 32'(e.word));
            check(pcl_rd == e.addr[PAGE_W-1:0], "R12", "pcl_rd", 32'(pcl_rd),
                  32'(e.addr[PAGE_W-1:0]));
            hold_addr = e.addr;
            have = 1;
         end
         if (phase[3] && have) begin
            check(mem_addr == hold_addr, "R3", "mem_addr held to T4",
                  32'(mem_addr), 32'(hold_addr));
            have = 0;
         end
      end
   end

   initial begin
      #(20 * 20000);
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      check(mem_addr == '0, "R2", "addr in reset", 32'(mem_addr), 0);
      check(instr_vld == 1'b0, "R2", "vld in reset", 32'(instr_vld), 0);
      check(instr == '0, "R2", "instr in reset", 32'(instr), 0);
      rst_n = 1'b1;
      plain("R2");                                   // first cycle: dummy at 0
      plain("R2");                                   // word 0 valid
      plain("R4");
      plain("R4");
      icycle("R4", 1, 10'h2F0, 0, '0, 0, 0, '0, 0); // jump
      icycle("R7", 1, 10'h100, 0, '0, 0, 0, '0, 0); // R5: request in dummy ignored
      plain("R5");
      icycle("R7", 0, '0, 0, '0, 0, 1, 8'h15, 0);   // low-byte write
      plain("R9");                                   // expect 215 dummy
      icycle("R9", 0, '0, 0, '0, 1, 0, '0, 0);      // skip
      plain("R6");
      icycle("R6", 1, 10'h3AA, 0, '0, 0, 0, '0, 1); // R5: dropped before T4
      icycle("R5", 1, 10'h3FE, 0, '0, 1, 0, '0, 0); // R10: skip + jump
      plain("R10");
      plain("R10");
      plain("R4");                                   // wrap 3FF -> 000
      icycle("R4", 1, 10'h050, 1, 10'h120, 0, 0, '0, 0); // R8: load beats return
      plain("R8");
      plain("R8");
      icycle("R8", 0, '0, 1, 10'h120, 0, 0, '0, 0); // return
      icycle("R11", 0, '0, 1, 10'h1FF, 0, 1, 8'h77, 0); // ignored in dummy
      icycle("R8", 0, '0, 1, 10'h133, 0, 1, 8'h77, 0);  // R8: return beats page write
      plain("R11");
      plain("R8");
      plain("R4");
      repeat (12) @(negedge clk);
      check(sb.size() == 0, "R4", "scoreboard drained", 32'(sb.size()), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule